// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Controller

This block is the control engine of one DMA channel that moves USB endpoint data between a packet buffer and system memory. Software drives it with a control write that carries three command bits: run, link and close-on-short. Two status outputs report its state. `st_en` says the channel is enabled, and `st_active` says the engine is busy fetching, moving or draining. The channel registers may be touched safely only while both are low.

Each buffer is described by a three-word descriptor in memory, read through a request/acknowledge port. The channel moves data one FIFO beat at a time while the endpoint raises its transfer request. An IN endpoint raises the request when it is free, and an OUT endpoint raises it when it is full. At the end of a buffer the channel waits for its data FIFO to empty. It then either stops or follows the link to the next descriptor.

The run and link bits together select one of four commands. Run=0 with link=0 stops at once. Run=1 with link=0 runs and stops at the end of the buffer. Run=0 with link=1 skips the loaded buffer and loads the next descriptor at once. Run=1 with link=1 runs and chains at the end of the buffer. When close-on-short is set, a short OUT packet ends the buffer early.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, `st_en` and `st_active` are 0, and neither `mrd_req` nor `xfer_go` is asserted.
- R2: A descriptor fetch reads three 32-bit words at P, P+4 and P+8, in that order, where P is the next-descriptor pointer. The words are the next pointer, the buffer address and a control word. The control word holds the byte length in bits 15:0, run in bit 16, link in bit 17 and close-on-short in bit 18. On completion the pointer, `xfer_addr`, `st_remain` and the command bits take the fetched values, and `st_en` takes the fetched run bit.
- R3: With run=1 and link=0, each completed beat adds the beat size (4 bytes) to `xfer_addr` and subtracts it from `st_remain`. When `st_remain` reaches 0 the channel drains, clears `st_en`, and fetches no descriptor.
- R4: With link=1, reaching the end of the buffer makes the channel fetch the next descriptor from the stored pointer once the FIFO is empty.
- R5: A control write with run=0 and link=1 loads the next descriptor at once, and no data beat is issued for the skipped buffer.
- R6: A control write with run=1 sets `st_en`, and a pending endpoint request then starts or resumes beats from the current address and count. A descriptor loaded with run=0 leaves `st_en` at 0, and no beat occurs until run is written again.
- R7: A control write with run=0 and link=0 while beats are being issued stops new beats at once. `st_en` and `st_active` stay 1 until `fifo_empty` is high, and both then clear on the next edge.
- R8: With close-on-short set, an `ep_short` pulse during a transfer ends the buffer early, leaving the untransferred count in `st_remain`. With it clear, `ep_short` has no effect.
- R9: Control writes that arrive during a descriptor fetch are ignored.
- R10: No beat is issued while `ep_req` is low or `st_en` is 0, and none is issued during a fetch.
- R11: A control write with run=0 and link=0 while the engine is idle clears `st_en` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_run | input | 1 | Run command bit |
| ctl_link | input | 1 | Link-to-next command bit |
| ctl_close | input | 1 | Close buffer on short packet |
| ptr_wr | input | 1 | Write strobe for the next-descriptor pointer |
| ptr_data | input | 32 | Next-descriptor pointer value |
| ep_req | input | 1 | Endpoint transfer request |
| ep_short | input | 1 | Short OUT packet received (pulse) |
| mrd_req | output | 1 | Descriptor word read request |
| mrd_addr | output | 32 | Descriptor word address |
| mrd_ack | input | 1 | Read acknowledge, data valid |
| mrd_data | input | 32 | Read data |
| xfer_go | output | 1 | Beat request to the data path |
| xfer_addr | output | 32 | Current buffer address |
| xfer_done | input | 1 | Beat accepted |
| fifo_empty | input | 1 | Channel data FIFO is empty |
| st_en | output | 1 | Status enable bit |
| st_active | output | 1 | Channel active |
| st_remain | output | 16 | Bytes left in the current buffer |

## Verification
A small table of seven descriptors is walked through all four commands. Each case is chosen to tell one outcome from another. A plain run-to-end must stop with no further fetch. A chained run must fetch exactly three more words. A chained descriptor carrying run=0 must sit still under a standing request.

A stop issued during a transfer is held against a full FIFO, so that draining is distinguished from stopping outright. A later resume shows that the address and count survive the stop. Short packets are sent with close-on-short both set and clear, so that early termination is distinguished from the signal being ignored.

Expected addresses and counts are computed from the descriptor lengths and the number of beats the bench itself granted.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    localparam int DMA_AW     = 32;
    localparam int DMA_LW     = 16;
    localparam int DMA_BEAT   = 4;
    localparam int DESC_WORDS = 3;
    localparam int CW_RUN     = 16;
    localparam int CW_LINK    = 17;
    localparam int CW_CLOSE   = 18;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_XFER,
        CH_DRAIN,
        CH_FETCH
    } ch_state_e;

    typedef struct packed {
        logic run;
        logic link;
        logic close;
    } cmd_t;

    typedef struct packed {
        logic [DMA_AW-1:0] next;
        logic [DMA_AW-1:0] base;
        logic [DMA_LW-1:0] len;
        cmd_t              cmd;
    } desc_t;

    function automatic desc_t build_desc(input logic [DMA_AW-1:0] w_next,
                                         input logic [DMA_AW-1:0] w_base,
                                         input logic [31:0]       w_ctl);
        desc_t d;
        d.next      = w_next;
        d.base      = w_base;
        d.len       = w_ctl[DMA_LW-1:0];
        d.cmd.run   = w_ctl[CW_RUN];
        d.cmd.link  = w_ctl[CW_LINK];
        d.cmd.close = w_ctl[CW_CLOSE];
        return d;
    endfunction
endpackage

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
    import dma_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DMA_AW-1:0] base,
    output logic              mrd_req,
    output logic [DMA_AW-1:0] mrd_addr,
    input  logic              mrd_ack,
    input  logic [31:0]       mrd_data,
    output logic              done,
    output desc_t             desc
);
    localparam int IDXW = $clog2(DESC_WORDS);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(DESC_WORDS - 1);

    logic              busy;
    logic [IDXW-1:0]   idx;
    logic [DMA_AW-1:0] base_q;
    logic [DMA_AW-1:0] held [DESC_WORDS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            idx    <= '0;
            base_q <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            idx    <= '0;
            base_q <= base;
        end else if (busy && mrd_ack) begin
            if (idx == LAST_IDX) busy <= 1'b0;
            else                 idx  <= idx + 1'b1;
        end
    end

    for (genvar g = 0; g < DESC_WORDS - 1; g++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst)                                      held[g] <= '0;
            else if (busy && mrd_ack && idx == IDXW'(g))  held[g] <= mrd_data;
        end
    end

    assign mrd_req  = busy;
    assign mrd_addr = base_q + (DMA_AW'(idx) << 2);
    assign done     = busy && mrd_ack && (idx == LAST_IDX);
    assign desc     = build_desc(held[0], held[1], mrd_data);
endmodule

// File: rtl/dma_buf_ctr.sv
module dma_buf_ctr
    import dma_chan_pkg::*;
#(
    parameter int BEAT_BYTES = DMA_BEAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DMA_AW-1:0] load_addr,
    input  logic [DMA_LW-1:0] load_len,
    input  logic              step,
    output logic [DMA_AW-1:0] addr,
    output logic [DMA_LW-1:0] remain,
    output logic              last
);
    localparam logic [DMA_LW-1:0] BEAT_L = DMA_LW'(BEAT_BYTES);
    localparam logic [DMA_AW-1:0] BEAT_A = DMA_AW'(BEAT_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            remain <= '0;
        end else if (load) begin
            addr   <= load_addr;
            remain <= load_len;
        end else if (step) begin
            addr   <= addr + BEAT_A;
            remain <= (remain > BEAT_L) ? remain - BEAT_L : '0;
        end
    end

    assign last = (remain <= BEAT_L);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter int BEAT_BYTES = DMA_BEAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              ctl_run,
    input  logic              ctl_link,
    input  logic              ctl_close,
    input  logic              ptr_wr,
    input  logic [DMA_AW-1:0] ptr_data,
    input  logic              ep_req,
    input  logic              ep_short,
    output logic              mrd_req,
    output logic [DMA_AW-1:0] mrd_addr,
    input  logic              mrd_ack,
    input  logic [31:0]       mrd_data,
    output logic              xfer_go,
    output logic [DMA_AW-1:0] xfer_addr,
    input  logic              xfer_done,
    input  logic              fifo_empty,
    output logic              st_en,
    output logic              st_active,
    output logic [DMA_LW-1:0] st_remain
);
    ch_state_e         state;
    cmd_t              cmd_q;
    logic              chain_q;
    logic [DMA_AW-1:0] next_ptr;

    logic  fetch_start, fetch_done, step, last, end_buf;
    desc_t fetched;

    dma_desc_fetch u_fetch (
        .clk      (clk),
        .rst      (rst),
        .start    (fetch_start),
        .base     (next_ptr),
        .mrd_req  (mrd_req),
        .mrd_addr (mrd_addr),
        .mrd_ack  (mrd_ack),
        .mrd_data (mrd_data),
        .done     (fetch_done),
        .desc     (fetched)
    );

    dma_buf_ctr #(.BEAT_BYTES(BEAT_BYTES)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .load      (fetch_done),
        .load_addr (fetched.base),
        .load_len  (fetched.len),
        .step      (step),
        .addr      (xfer_addr),
        .remain    (st_remain),
        .last      (last)
    );

    assign xfer_go     = (state == CH_XFER) && ep_req && (st_remain != '0);
    assign step        = xfer_go && xfer_done;
    assign end_buf     = (step && last) || (ep_short && cmd_q.close);
    assign fetch_start = ((state == CH_IDLE) && ctl_wr && !ctl_run && ctl_link) ||
                         ((state == CH_DRAIN) && fifo_empty && chain_q);
    assign st_active   = (state != CH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CH_IDLE;
            cmd_q    <= '0;
            chain_q  <= 1'b0;
            st_en    <= 1'b0;
            next_ptr <= '0;
        end else begin
            if (fetch_done)                        next_ptr <= fetched.next;
            else if (ptr_wr && state != CH_FETCH)  next_ptr <= ptr_data;

            unique case (state)
                CH_IDLE: begin
                    if (ctl_wr) begin
                        cmd_q <= '{run: ctl_run, link: ctl_link, close: ctl_close};
                        st_en <= ctl_run;
                        if (!ctl_run && ctl_link) state <= CH_FETCH;
                    end else if (st_en && ep_req && st_remain != '0) begin
                        state <= CH_XFER;
                    end
                end
                CH_XFER: begin
                    if (ctl_wr) begin
                        cmd_q <= '{run: ctl_run, link: ctl_link, close: ctl_close};
                    end
                    if (ctl_wr && !ctl_run) begin
                        chain_q <= ctl_link;
                        state   <= CH_DRAIN;
                    end else if (end_buf) begin
                        chain_q <= ctl_wr ? ctl_link : cmd_q.link;
                        state   <= CH_DRAIN;
                    end else if (!ep_req) begin
                        state <= CH_IDLE;
                    end
                end
                CH_DRAIN: begin
                    if (fifo_empty) begin
                        st_en <= 1'b0;
                        state <= chain_q ? CH_FETCH : CH_IDLE;
                    end
                end
                CH_FETCH: begin
                    if (fetch_done) begin
                        cmd_q <= fetched.cmd;
                        st_en <= fetched.cmd.run;
                        state <= CH_IDLE;
                    end
                end
                default: state <= CH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk
    import dma_chan_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mrd_req,
    input logic [DMA_AW-1:0] mrd_addr,
    input logic              mrd_ack,
    input logic              xfer_go,
    input logic              xfer_done,
    input logic              fifo_empty,
    input logic              st_en,
    input logic              st_active,
    input logic              ep_req,
    input logic [DMA_LW-1:0] st_remain
);
    AST_GO_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        xfer_go |-> (st_en && st_active && ep_req)); // R10

    AST_NO_GO_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
        mrd_req |-> !xfer_go); // R5

    AST_MRD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mrd_req && !mrd_ack) |=> (mrd_req && $stable(mrd_addr))); // R2

    AST_EN_FALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        ($fell(st_en) && $past(st_active)) |-> $past(fifo_empty)); // R7

    AST_STEP_DECR: assert property (@(posedge clk) disable iff (rst)
        (xfer_go && xfer_done) |=> (st_remain < $past(st_remain))); // R3
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mrd_req    (mrd_req),
    .mrd_addr   (mrd_addr),
    .mrd_ack    (mrd_ack),
    .xfer_go    (xfer_go),
    .xfer_done  (xfer_done),
    .fifo_empty (fifo_empty),
    .st_en      (st_en),
    .st_active  (st_active),
    .ep_req     (ep_req),
    .st_remain  (st_remain)
);

// File: tb/dma_chan_ctrl_tb.sv
module dma_chan_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 0, ctl_run = 0, ctl_link = 0, ctl_close = 0;
    logic        ptr_wr = 0;
    logic [31:0] ptr_data = 0;
    logic        ep_req = 0, ep_short = 0;
    logic        mrd_req;
    logic [31:0] mrd_addr;
    logic        mrd_ack = 0;
    logic [31:0] mrd_data = 0;
    logic        xfer_go;
    logic [31:0] xfer_addr;
    logic        xfer_done = 0;
    logic        fifo_empty = 1;
    logic        st_en, st_active;
    logic [15:0] st_remain;

    int checks = 0, failures = 0;
    int beats = 0, mrd_cnt = 0, cyc = 0;
    logic [31:0] mem [64];
    logic [31:0] mlog [32];

    always #2 clk = ~clk;

    dma_chan_ctrl u_dut (.*);

    // memory and data-path responders
    always @(negedge clk) begin
        if (mrd_req && !mrd_ack) begin
            mrd_ack  <= 1'b1;
            mrd_data <= mem[mrd_addr[7:2]];
            if (mrd_cnt < 32) mlog[mrd_cnt] = mrd_addr;
            mrd_cnt  = mrd_cnt + 1;
        end else begin
            mrd_ack <= 1'b0;
        end
        if (xfer_go && !xfer_done) begin
            xfer_done <= 1'b1;
            beats = beats + 1;
        end else begin
            xfer_done <= 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired: act=%0d exp=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_desc(input int slot, input logic [31:0] nxt, input logic [31:0] buf_a,
                            input int len, input logic run, input logic link, input logic cls);
        mem[slot*4]     = nxt;
        mem[slot*4 + 1] = buf_a;
        mem[slot*4 + 2] = {13'd0, cls, link, run, 16'(len)};
    endtask

    task automatic ctl(input logic run, input logic link, input logic cls);
        ctl_run = run; ctl_link = link; ctl_close = cls; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (st_active) @(negedge clk);
    endtask

    task automatic wait_en_low();
        while (st_en) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 0;
        set_desc(1, 32'h20, 32'h1000, 16, 1, 0, 0);
        set_desc(2, 32'h30, 32'h2000,  8, 1, 1, 0);
        set_desc(3, 32'h40, 32'h3000, 12, 0, 0, 0);
        set_desc(4, 32'h50, 32'h4000, 40, 1, 0, 0);
        set_desc(5, 32'h60, 32'h5000, 40, 1, 0, 1);
        set_desc(6, 32'h70, 32'h6000, 20, 1, 0, 0);
        set_desc(7, 32'h80, 32'h7000, 12, 0, 0, 0);

        wait_cycles(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 st_en", st_en, 0);
        chk("R1 st_active", st_active, 0);
        chk("R1 mrd_req", mrd_req, 0);
        chk("R1 xfer_go", xfer_go, 0);

        // R5 / R2 skip loads descriptor 1
        ptr_data = 32'h10; ptr_wr = 1; @(negedge clk); ptr_wr = 0;
        beats = 0;
        ctl(0, 1, 0);
        wait_idle();
        chk("R2 word count", mrd_cnt, 3);
        chk("R2 addr w0", mlog[0], 32'h10);
        chk("R2 addr w1", mlog[1], 32'h14);
        chk("R2 addr w2", mlog[2], 32'h18);
        chk("R2 st_en from run", st_en, 1);
        chk("R2 buffer addr", xfer_addr, 32'h1000);
        chk("R2 remain", st_remain, 16);
        chk("R5 no beat on skip", beats, 0);

        // R10 no request, no beat
        wait_cycles(10);
        chk("R10 idle without ep_req", beats, 0);

        // R3 run to end and stop
        ep_req = 1;
        wait_en_low();
        wait_idle();
        ep_req = 0;
        chk("R3 beats", beats, 16 / 4);
        chk("R3 remain", st_remain, 0);
        chk("R3 end addr", xfer_addr, 32'h1000 + 16);
        wait_cycles(5);
        chk("R3 no fetch after stop", mrd_cnt, 3);

        // R4 chain: descriptor 2 links to 3
        ctl(0, 1, 0);
        wait_idle();
        chk("R4 d2 loaded", xfer_addr, 32'h2000);
        beats = 0;
        ep_req = 1;
        do @(negedge clk); while (!(mrd_cnt == 9 && !st_active));
        chk("R4 beats d2", beats, 8 / 4);
        chk("R4 chain addr w0", mlog[6], 32'h30);
        chk("R4 chain addr w2", mlog[8], 32'h38);
        chk("R4 d3 buffer", xfer_addr, 32'h3000);
        chk("R4 d3 remain", st_remain, 12);
        chk("R6 run=0 descriptor leaves st_en", st_en, 0);
        wait_cycles(20);
        chk("R6 no beat before rewrite", beats, 2);

        // R6 write run to start the pending request
        ctl(1, 0, 0);
        chk("R6 st_en set", st_en, 1);
        wait_en_low();
        wait_idle();
        chk("R6 beats after rewrite", beats, 2 + 12 / 4);
        chk("R6 end addr", xfer_addr, 32'h3000 + 12);
        ep_req = 0;

        // R7 stop now during service, drain before clearing
        ctl(0, 1, 0);
        wait_idle();
        chk("R7 d4 loaded", xfer_addr, 32'h4000);
        fifo_empty = 0;
        beats = 0;
        ep_req = 1;
        while (beats < 2) @(negedge clk);
        ctl(0, 0, 0);
        begin
            int b_at_stop;
            b_at_stop = beats;
            wait_cycles(10);
            chk("R7 no beats while draining", beats, b_at_stop);
            chk("R7 st_en held", st_en, 1);
            chk("R7 active held", st_active, 1);
            chk("R7 xfer_go low", xfer_go, 0);
            fifo_empty = 1;
            @(negedge clk);
            chk("R7 st_en cleared", st_en, 0);
            chk("R7 active cleared", st_active, 0);
            chk("R7 remain kept", st_remain, 32'(40 - 4 * b_at_stop));
            // R6 resume
            ctl(1, 0, 0);
            wait_en_low();
            wait_idle();
            chk("R6 resume beats", beats, 40 / 4);
            chk("R6 resume end addr", xfer_addr, 32'h4000 + 40);
            chk("R6 resume remain", st_remain, 0);
        end
        ep_req = 0;

        // R8 short packet with close enabled
        ctl(0, 1, 0);
        wait_idle();
        beats = 0;
        ep_req = 1;
        while (beats < 1) @(negedge clk);
        ep_short = 1; @(negedge clk); ep_short = 0;
        wait_en_low();
        wait_idle();
        ep_req = 0;
        chk("R8 early end", (beats < 10) ? 1 : 0, 1);
        chk("R8 remain after short", st_remain, 32'(40 - 4 * beats));
        chk("R8 addr after short", xfer_addr, 32'h5000 + 32'(4 * beats));

        // R8 short packet ignored with close clear
        ctl(0, 1, 0);
        wait_idle();
        beats = 0;
        ep_req = 1;
        while (beats < 1) @(negedge clk);
        ep_short = 1; @(negedge clk); ep_short = 0;
        wait_en_low();
        wait_idle();
        ep_req = 0;
        chk("R8 short ignored beats", beats, 20 / 4);
        chk("R8 short ignored remain", st_remain, 0);

        // R9 control write during fetch is ignored
        ctl(0, 1, 0);
        ctl(1, 0, 0);
        wait_idle();
        chk("R9 d7 loaded", xfer_addr, 32'h7000);
        chk("R9 write in fetch ignored", st_en, 0);

        // R11 stop now while idle
        ctl(1, 0, 0);
        chk("R11 st_en set", st_en, 1);
        ctl(0, 0, 0);
        chk("R11 st_en cleared", st_en, 0);
        beats = 0;
        ep_req = 1;
        wait_cycles(10);
        chk("R10 no beat with st_en low", beats, 0);
        ep_req = 0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule